// File: doc/BRIEF.md
# Two-Tier Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a small signal-processing core. On every clock cycle in which it holds no pending request, it looks at all peripheral request lines, two external interrupt pins and six exception sources. It then picks one winner and latches it as a single request for the core. The request carries a vector number, a level bit and a one-hot indication of the core channel (0 to 6) that the winning peripheral maps to.

Masking works in two stages. First, a per-channel enable and a separate enable for each external pin decide which level-0 sources may compete at all. Second, a two-bit global mask either admits level 0 or blocks all of it. The six exception sources form level 1. No enable or mask ever stops them, and any one of them outranks every level-0 source. The latched request stays unchanged until the core pulses the acknowledge input. The block arbitrates again on the cycle after that. Software configures the block through a simple synchronous write port and a combinational read port.

Top module: `irq_arb_top`

## Requirements
- R1: Among enabled, pending peripheral sources, the one mapped to the highest channel number wins. When two sources share a channel, the lower source index wins.
- R2: Each peripheral source has a 3-bit channel field. Source s sits in register word 2 + s/8, at bits [4*(s%8)+2 : 4*(s%8)]. The field value 7 marks the source as unassigned, and such a source never requests.
- R3: Control word 0, bits [6:0], holds one enable per channel. A peripheral mapped to a channel whose bit is 0 never wins, and the best remaining enabled source wins instead.
- R4: Control word 0, bit 8, enables pin A and bit 9 enables pin B. An enabled pin outranks every peripheral, and pin A outranks pin B. Clearing one pin's bit leaves the other pin and all peripherals unaffected.
- R5: The global mask is word 1, bits [1:0], and resets to 2'b11. The value 2'b11 blocks every level-0 source (both pins and all peripherals). The values 2'b00, 2'b01 and 2'b10 all admit level 0.
- R6: The six exception inputs exc_req[5:0] are level 1. They are never blocked by the mask or by any enable, bit 0 has the highest priority, and any of them outranks every level-0 source.
- R7: The vector is VEC_BASE plus a source index. Exception k gives index k, pin A gives 6, pin B gives 7 and peripheral i gives 8 + i. irq_level is 1 for exceptions and 0 otherwise.
- R8: core_ch is one-hot at the winning peripheral's channel. It is all zeros for pin and exception winners and when no request is held.
- R9: Once irq_valid is 1, the vector, level and channel outputs hold until irq_ack is sampled high. irq_valid is then 0 for one cycle, and the block arbitrates again on the next cycle. An acknowledge while no request is held has no effect.
- R10: After reset, word 0 and all map words read 0 and word 1 reads 3. Every written field reads back its value, and reserved bits read 0.
- R11: When no request is held, the sources present at a rising clock edge appear on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| periph_req | input | NUM_PERIPH | Peripheral request lines, level-sensitive |
| ext_irq_a | input | 1 | External interrupt pin A, active high |
| ext_irq_b | input | 1 | External interrupt pin B, active high |
| exc_req | input | 6 | Exception requests, bit 0 highest priority |
| irq_ack | input | 1 | Acknowledge pulse from the core |
| irq_valid | output | 1 | A request is held for the core |
| irq_vector | output | 8 | Service vector of the held request |
| irq_level | output | 1 | 1 for an exception, 0 for a level-0 source |
| core_ch | output | 7 | One-hot core channel of a peripheral winner |

## Verification
The assertions assume that the core sends an acknowledge only after it has seen irq_valid, and that request lines are sampled synchronously with no setup hazards. The bench changes every input and register only at falling edges. It performs register writes only while no request is held and all request lines are low, so a write can never race a latch. Random stimulus keeps exceptions rare, so that level-0 arbitration under random maps, enables and mask values dominates the run. Directed cases cover channel ties, unassigned sources, pin enables, every mask value and acknowledges while idle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int REG_AW    = 4;
    localparam int DATA_W    = 32;
    localparam int NUM_CH    = 7;
    localparam int CH_W      = 3;
    localparam int NUM_EXC   = 6;
    localparam int VEC_W     = 8;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MASK = 1;
    localparam int ADDR_MAP  = 2;
    localparam int MAP_PER_WORD = 8;
    localparam int MAP_STRIDE   = 4;

    localparam int IDX_PIN_A  = NUM_EXC;
    localparam int IDX_PIN_B  = NUM_EXC + 1;
    localparam int IDX_PERIPH = NUM_EXC + 2;

    localparam logic [1:0] GMASK_L1_ONLY = 2'b11;
    localparam logic [CH_W-1:0] CH_UNASSIGNED = 3'd7;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_EXC,
        WIN_PIN,
        WIN_PERIPH
    } win_kind_e;

    typedef struct packed {
        logic              valid;
        logic              level;
        logic [VEC_W-1:0]  vec;
        logic [NUM_CH-1:0] ch_oh;
    } irq_pick_t;

    function automatic logic [NUM_CH-1:0] ch_onehot(input logic [CH_W-1:0] c);
        logic [NUM_CH-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (c == CH_W'(k)) r[k] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_we,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_CH-1:0]          ch_en,
    output logic [1:0]                 pin_en,
    output logic [1:0]                 gmask,
    output logic [NUM_PERIPH*CH_W-1:0] map_flat
);

    logic [NUM_CH-1:0] ch_en_q;
    logic [1:0]        pin_en_q;
    logic [1:0]        gmask_q;
    logic [CH_W-1:0]   map_q [NUM_PERIPH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_en_q  <= '0;
            pin_en_q <= '0;
            gmask_q  <= GMASK_L1_ONLY;
            for (int s = 0; s < NUM_PERIPH; s++) map_q[s] <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_AW'(ADDR_CTRL)) begin
                ch_en_q  <= reg_wdata[NUM_CH-1:0];
                pin_en_q <= reg_wdata[9:8];
            end
            if (reg_addr == REG_AW'(ADDR_MASK)) gmask_q <= reg_wdata[1:0];
            for (int s = 0; s < NUM_PERIPH; s++) begin
                if (reg_addr == REG_AW'(ADDR_MAP + s / MAP_PER_WORD))
                    map_q[s] <= reg_wdata[MAP_STRIDE*(s % MAP_PER_WORD) +: CH_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(ADDR_CTRL)) begin
            reg_rdata[NUM_CH-1:0] = ch_en_q;
            reg_rdata[9:8]        = pin_en_q;
        end
        if (reg_addr == REG_AW'(ADDR_MASK)) reg_rdata[1:0] = gmask_q;
        for (int s = 0; s < NUM_PERIPH; s++) begin
            if (reg_addr == REG_AW'(ADDR_MAP + s / MAP_PER_WORD))
                reg_rdata[MAP_STRIDE*(s % MAP_PER_WORD) +: CH_W] = map_q[s];
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_PERIPH; s++) map_flat[s*CH_W +: CH_W] = map_q[s];
    end

    assign ch_en  = ch_en_q;
    assign pin_en = pin_en_q;
    assign gmask  = gmask_q;

    // R5: the global mask comes out of reset admitting level 1 only
    p_mask_reset_r5: assert property (@(posedge clk) rst |=> (gmask_q == GMASK_L1_ONLY));

endmodule

// File: rtl/irq_arb_periph_sel.sv
module irq_arb_periph_sel
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 16,
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PERIPH-1:0]      req,
    input  logic [NUM_PERIPH*CH_W-1:0] map_flat,
    input  logic [NUM_CH-1:0]          ch_en,
    output logic                       found,
    output logic [IDX_W-1:0]           win_idx,
    output logic [CH_W-1:0]            win_ch
);

    // channel 7 is "unassigned": its enable is a constant zero
    logic [(1<<CH_W)-1:0] en_ext;
    assign en_ext = {{((1<<CH_W)-NUM_CH){1'b0}}, ch_en};

    logic [NUM_PERIPH-1:0] cand;

    generate
        for (genvar s = 0; s < NUM_PERIPH; s++) begin : g_cand
            assign cand[s] = req[s] && en_ext[map_flat[s*CH_W +: CH_W]];
        end
    endgenerate

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_ch  = '0;
        for (int s = 0; s < NUM_PERIPH; s++) begin
            if (cand[s] && (!found || map_flat[s*CH_W +: CH_W] > win_ch)) begin
                found   = 1'b1;
                win_idx = IDX_W'(s);
                win_ch  = map_flat[s*CH_W +: CH_W];
            end
        end
    end

    // R2 R3: a chosen source is actually requesting and never sits on an unassigned channel
    p_win_real_r3: assert property (@(posedge clk) disable iff (rst)
        found |-> (req[win_idx] && (win_ch != CH_UNASSIGNED)));

endmodule

// File: rtl/irq_arb_resolve.sv
module irq_arb_resolve
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h10,
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic               pin_a,
    input  logic               pin_b,
    input  logic [1:0]         pin_en,
    input  logic [1:0]         gmask,
    input  logic               p_found,
    input  logic [IDX_W-1:0]   p_idx,
    input  logic [CH_W-1:0]    p_ch,
    output irq_pick_t          pick
);

    logic      lvl0_open;
    win_kind_e kind;
    logic [VEC_W-1:0] exc_idx;

    assign lvl0_open = (gmask != GMASK_L1_ONLY);

    always_comb begin
        exc_idx = '0;
        for (int k = NUM_EXC - 1; k >= 0; k--) begin
            if (exc_req[k]) exc_idx = VEC_W'(k);
        end
    end

    always_comb begin
        if (exc_req != '0)                          kind = WIN_EXC;
        else if (lvl0_open && ((pin_a && pin_en[0]) ||
                               (pin_b && pin_en[1])))  kind = WIN_PIN;
        else if (lvl0_open && p_found)              kind = WIN_PERIPH;
        else                                        kind = WIN_NONE;
    end

    always_comb begin
        pick = '0;
        case (kind)
            WIN_EXC: begin
                pick.valid = 1'b1;
                pick.level = 1'b1;
                pick.vec   = VEC_BASE + exc_idx;
            end
            WIN_PIN: begin
                pick.valid = 1'b1;
                pick.vec   = (pin_a && pin_en[0]) ? VEC_BASE + VEC_W'(IDX_PIN_A)
                                                  : VEC_BASE + VEC_W'(IDX_PIN_B);
            end
            WIN_PERIPH: begin
                pick.valid = 1'b1;
                pick.vec   = VEC_BASE + VEC_W'(IDX_PERIPH) + VEC_W'(p_idx);
                pick.ch_oh = ch_onehot(p_ch);
            end
            default: pick = '0;
        endcase
    end

    // R5: with level 0 closed only a level-1 pick may appear
    p_mask_block_r5: assert property (@(posedge clk) disable iff (rst)
        (gmask == GMASK_L1_ONLY) |-> (!pick.valid || pick.level));

    // R6: any exception yields a level-1 pick regardless of enables and mask
    p_exc_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (exc_req != '0) |-> (pick.valid && pick.level && pick.ch_oh == '0));

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 16,
    parameter logic [7:0] VEC_BASE = 8'h10,
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [3:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  ext_irq_a,
    input  logic                  ext_irq_b,
    input  logic [5:0]            exc_req,
    input  logic                  irq_ack,
    output logic                  irq_valid,
    output logic [7:0]            irq_vector,
    output logic                  irq_level,
    output logic [6:0]            core_ch
);

    logic [NUM_CH-1:0]          ch_en;
    logic [1:0]                 pin_en;
    logic [1:0]                 gmask;
    logic [NUM_PERIPH*CH_W-1:0] map_flat;
    logic                       p_found;
    logic [IDX_W-1:0]           p_idx;
    logic [CH_W-1:0]            p_ch;
    irq_pick_t                  pick_d;
    irq_pick_t                  pick_q;

    irq_arb_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_en(ch_en), .pin_en(pin_en), .gmask(gmask), .map_flat(map_flat)
    );

    irq_arb_periph_sel #(.NUM_PERIPH(NUM_PERIPH)) u_sel (
        .clk(clk), .rst(rst),
        .req(periph_req), .map_flat(map_flat), .ch_en(ch_en),
        .found(p_found), .win_idx(p_idx), .win_ch(p_ch)
    );

    irq_arb_resolve #(.NUM_PERIPH(NUM_PERIPH), .VEC_BASE(VEC_BASE)) u_res (
        .clk(clk), .rst(rst),
        .exc_req(exc_req), .pin_a(ext_irq_a), .pin_b(ext_irq_b),
        .pin_en(pin_en), .gmask(gmask),
        .p_found(p_found), .p_idx(p_idx), .p_ch(p_ch),
        .pick(pick_d)
    );

    always_ff @(posedge clk) begin
        if (rst)                  pick_q <= '0;
        else if (!pick_q.valid)   pick_q <= pick_d;
        else if (irq_ack)         pick_q <= '0;
    end

    assign irq_valid  = pick_q.valid;
    assign irq_vector = pick_q.vec;
    assign irq_level  = pick_q.level;
    assign core_ch    = pick_q.ch_oh;

    // R9: an unacknowledged request holds every output
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vector) &&
                                     $stable(irq_level) && $stable(core_ch)));

    // R9: an acknowledge drops the request for one cycle
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack) |=> !irq_valid);

    // R6 R11: an exception seen while idle is latched as level 1 at the next edge
    p_exc_latch_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_valid && exc_req != '0) |=> (irq_valid && irq_level));

    // R8: the channel output is at most one-hot and silent for non-peripheral winners
    p_ch_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_ch) && ((irq_level || !irq_valid) -> core_ch == '0));

endmodule

// File: tb/irq_arb_top_tb.sv
module irq_arb_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam logic [7:0] BASE = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] periph_req = '0;
    logic        ext_irq_a = 1'b0;
    logic        ext_irq_b = 1'b0;
    logic [5:0]  exc_req = '0;
    logic        irq_ack = 1'b0;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_level;
    logic [6:0]  core_ch;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0] m_ch_en = '0;
    logic [1:0] m_pin_en = '0;
    logic [1:0] m_gmask = 2'b11;
    logic [2:0] m_map [NP];

    irq_arb_top #(.NUM_PERIPH(NP), .VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .ext_irq_a(ext_irq_a), .ext_irq_b(ext_irq_b),
        .exc_req(exc_req), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level), .core_ch(core_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] outs();
        return {irq_valid, irq_level, irq_vector, core_ch};
    endfunction

    // expected {valid, level, vector, channel one-hot} from the requirements
    function automatic logic [16:0] model(input logic [5:0] e, input logic pa, input logic pb,
                                          input logic [NP-1:0] pr);
        int best = -1;
        logic [2:0] bc = '0;
        if (e != '0) begin
            for (int k = 5; k >= 0; k--) if (e[k]) best = k;
            return {1'b1, 1'b1, BASE + 8'(best), 7'd0};
        end
        if (m_gmask == 2'b11) return '0;
        if (pa && m_pin_en[0]) return {1'b1, 1'b0, BASE + 8'd6, 7'd0};
        if (pb && m_pin_en[1]) return {1'b1, 1'b0, BASE + 8'd7, 7'd0};
        for (int i = 0; i < NP; i++) begin
            if (pr[i] && m_map[i] != 3'd7 && m_ch_en[m_map[i]] && (best < 0 || m_map[i] > bc)) begin
                best = i;
                bc = m_map[i];
            end
        end
        if (best < 0) return '0;
        return {1'b1, 1'b0, BASE + 8'd8 + 8'(best), 7'(1) << bc};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_ctrl(input logic [6:0] ce, input logic [1:0] pe);
        m_ch_en = ce; m_pin_en = pe;
        wr(4'd0, {22'd0, pe, 1'b0, ce});
    endtask

    task automatic set_mask(input logic [1:0] g);
        m_gmask = g;
        wr(4'd1, {30'd0, g});
    endtask

    task automatic set_maps();
        for (int w = 0; w < NP / 8; w++) begin
            logic [31:0] d = '0;
            for (int k = 0; k < 8; k++) d[4*k +: 3] = m_map[w*8 + k];
            wr(4'(2 + w), d);
        end
    endtask

    // caller is at a falling edge with no request held and all sources low
    task automatic apply(input string tag, input logic [5:0] e, input logic pa, input logic pb,
                         input logic [NP-1:0] pr);
        logic [16:0] exp;
        exc_req = e; ext_irq_a = pa; ext_irq_b = pb; periph_req = pr;
        exp = model(e, pa, pb, pr);
        @(negedge clk);
        check(tag, 32'(outs()), 32'(exp));
        if (exp[16]) begin
            exc_req = 6'($urandom); periph_req = ~pr; ext_irq_a = ~pa; ext_irq_b = ~pb;
            @(negedge clk);
            check("R9 hold until ack", 32'(outs()), 32'(exp));
            irq_ack = 1'b1; exc_req = '0; periph_req = '0; ext_irq_a = 1'b0; ext_irq_b = 1'b0;
            @(negedge clk);
            irq_ack = 1'b0;
            check("R9 cleared after ack", 32'(irq_valid), 32'd0);
        end else begin
            exc_req = '0; periph_req = '0; ext_irq_a = 1'b0; ext_irq_b = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) m_map[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset values, R8 idle outputs
        reg_addr = 4'd0; #1 check("R10 ctrl reset", reg_rdata, 32'd0);
        reg_addr = 4'd1; #1 check("R10 R5 mask reset", reg_rdata, 32'd3);
        reg_addr = 4'd2; #1 check("R10 map reset", reg_rdata, 32'd0);
        check("R8 idle outputs", 32'(outs()), 32'd0);
        @(negedge clk);

        // R5: after reset level 0 is closed
        set_ctrl(7'h7f, 2'b11);
        apply("R5 reset mask blocks level 0", 6'd0, 1'b1, 1'b1, 16'hffff);
        set_mask(2'b01);

        // R1 highest channel, tie to lower index
        m_map[3] = 3'd5; m_map[9] = 3'd5; m_map[12] = 3'd2;
        set_maps();
        apply("R1 tie to lower index", 6'd0, 1'b0, 1'b0, 16'h1208);
        apply("R1 R7 highest channel", 6'd0, 1'b0, 1'b0, 16'h1200);

        // R3 disabled channel
        set_ctrl(7'h5f, 2'b11);
        apply("R3 disabled channel skipped", 6'd0, 1'b0, 1'b0, 16'h1208);

        // R2 unassigned field and readback
        m_map[12] = 3'd7; set_maps();
        reg_addr = 4'd3; #1 check("R10 R2 map readback", reg_rdata, 32'h0007_0050);
        @(negedge clk);
        apply("R2 unassigned source silent", 6'd0, 1'b0, 1'b0, 16'h1000);

        // R4 pins
        set_ctrl(7'h7f, 2'b11);
        reg_addr = 4'd0; #1 check("R10 ctrl readback", reg_rdata, 32'h37f);
        @(negedge clk);
        apply("R4 pin A first", 6'd0, 1'b1, 1'b1, 16'h0008);
        set_ctrl(7'h7f, 2'b10);
        apply("R4 pin A disabled, pin B wins", 6'd0, 1'b1, 1'b1, 16'h0008);
        set_ctrl(7'h7f, 2'b00);
        apply("R4 pins disabled, peripheral wins", 6'd0, 1'b1, 1'b1, 16'h0008);

        // R5 every mask value
        set_mask(2'b00); apply("R5 mask 00 admits", 6'd0, 1'b0, 1'b0, 16'h0200);
        set_mask(2'b10); apply("R5 mask 10 admits", 6'd0, 1'b0, 1'b0, 16'h0200);
        set_mask(2'b11); apply("R5 mask 11 blocks", 6'd0, 1'b0, 1'b0, 16'h0200);

        // R6 exceptions through mask, ordering
        apply("R6 exception passes mask", 6'b101000, 1'b1, 1'b1, 16'hffff);
        apply("R6 reset source first", 6'b111111, 1'b0, 1'b0, 16'h0);
        set_mask(2'b01);
        set_ctrl(7'h00, 2'b00);
        apply("R6 exception above level 0", 6'b100000, 1'b1, 1'b0, 16'hffff);

        // R9 ack while idle is ignored; R11 capture on the same edge
        set_ctrl(7'h7f, 2'b11);
        irq_ack = 1'b1;
        periph_req = 16'h0008;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R9 R11 ack while idle ignored", 32'(outs()), 32'(model(6'd0, 1'b0, 1'b0, 16'h0008)));
        irq_ack = 1'b1; periph_req = '0;
        @(negedge clk);
        irq_ack = 1'b0;
        @(negedge clk);

        // random mix
        for (int n = 0; n < 600; n++) begin
            if (n % 25 == 0) begin
                for (int i = 0; i < NP; i++) m_map[i] = 3'($urandom);
                set_maps();
                set_ctrl(7'($urandom), 2'($urandom));
                set_mask(2'($urandom));
            end
            apply("R1 R7 random", ($urandom % 6 == 0) ? 6'($urandom) : 6'd0,
                  1'($urandom % 5 == 0), 1'($urandom % 5 == 0), 16'($urandom) & 16'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule